// File: doc/BRIEF.md
# TileLink-UL Request Legality Checker

This block watches the request channel of a 32-bit TileLink Uncached Lightweight link. The host's valid, opcode, size and mask wires go straight through it to the device, and the device's ready goes straight back, so the handshake gains no cycle. On every beat where valid and ready are both high, the checker sorts the opcode into one of three classes: a read (Get), a full-word write (PutFullData) or a byte-masked write (PutPartialData). It then tests the size and the lane mask against the rules for that class.

One clock after an accepted beat, the block raises a violation flag for exactly one cycle and puts a 3-bit error class beside it. A host wrapper or a device front end can use the pair to refuse the request or to log it. The mask rules change with the opcode. A read must light one unbroken run of lanes whose length fits the size. A full write must light every lane at the full size. A partial write may use any sparse pattern, as long as it is not empty and does not hold more lanes than the size allows.

Top module: `tlul_req_guard`

## Requirements
- R1: `a_valid_o`, `a_opcode_o`, `a_size_o` and `a_mask_o` equal the matching host inputs in the same cycle, and `a_ready_o` equals `a_ready_i` in the same cycle.
- R2: A beat is checked only when `a_valid_i` and `a_ready_i` are both high. The result shows on `viol_o`/`err_code_o` in the cycle after that beat, for that one cycle only. After any cycle without an accepted beat, both outputs are 0.
- R3: `err_code_o` encodings are: 0 no error, 1 bad opcode, 2 size too large, 3 size and mask disagree, 4 read mask has a gap, 5 full write with missing lanes. `viol_o` is 1 exactly when `err_code_o` is nonzero.
- R4: The opcode values are 0 for a full write, 1 for a partial write and 4 for a read. Any other value yields code 1, whatever the size and mask are.
- R5: With a legal opcode, a size above 2 (more than 4 bytes) yields code 2, whatever the mask is.
- R6: A read whose mask has set lanes split by a clear lane (for example 4'b1001 or 4'b1101) yields code 4. This check takes priority over the lane count.
- R7: A read with an unbroken mask is legal only with 1 set lane for size 0, 2 set lanes for size 1, and 3 or 4 set lanes for size 2. Any other count, including an empty mask, yields code 3.
- R8: A full write with size below 2 yields code 3. A full write with size 2 and a mask other than 4'b1111 yields code 5. Size 2 with mask 4'b1111 is legal.
- R9: A partial write with 1 to 2^size set lanes, in any pattern, is legal. An empty mask, or one with more set lanes than 2^size, yields code 3.
- R10: While `rst_n` is low, `viol_o` and `err_code_o` are 0, even with an illegal beat on the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_valid_i | input | 1 | Request valid from the host |
| a_opcode_i | input | 3 | Request opcode from the host |
| a_size_i | input | 2 | Request size, log2 of the byte count |
| a_mask_i | input | 4 | Byte-lane enables, one bit per lane |
| a_ready_o | output | 1 | Ready returned to the host |
| a_valid_o | output | 1 | Request valid to the device |
| a_opcode_o | output | 3 | Opcode to the device |
| a_size_o | output | 2 | Size to the device |
| a_mask_o | output | 4 | Lane mask to the device |
| a_ready_i | input | 1 | Ready from the device |
| viol_o | output | 1 | One-cycle violation pulse for the previous accepted beat |
| err_code_o | output | 3 | Error class for the previous accepted beat |

## Verification
The only state in the block is the result register. A wrong value there shows at `viol_o`/`err_code_o` one clock after the beat that caused it. A sticky register fails to clear after an idle cycle, and a wrong capture condition gives a result after a beat that was not accepted. Mistakes in the classifier or in the lane analysis show as a wrong code one cycle after the beat. The bench finds them with a full sweep over every opcode, size and mask, compared against a model that finds gaps with a different method from the RTL.

// File: rtl/tlul_guard_pkg.sv
package tlul_guard_pkg;

  localparam logic [2:0] OPC_PUT_FULL = 3'd0;
  localparam logic [2:0] OPC_PUT_PART = 3'd1;
  localparam logic [2:0] OPC_GET      = 3'd4;

  typedef enum logic [1:0] {
    CLS_PUT_FULL = 2'd0,
    CLS_PUT_PART = 2'd1,
    CLS_GET      = 2'd2,
    CLS_BAD      = 2'd3
  } req_cls_e;

  typedef enum logic [2:0] {
    ERR_NONE      = 3'd0,
    ERR_OPCODE    = 3'd1,
    ERR_SIZE      = 3'd2,
    ERR_SIZE_MASK = 3'd3,
    ERR_GAP       = 3'd4,
    ERR_PFD_LANES = 3'd5
  } guard_err_e;

endpackage

// File: rtl/tlul_opc_class.sv
module tlul_opc_class
  import tlul_guard_pkg::*;
(
  input  logic [2:0] opcode_i,
  output req_cls_e   cls_o
);
  always_comb begin
    unique case (opcode_i)
      OPC_PUT_FULL: cls_o = CLS_PUT_FULL;
      OPC_PUT_PART: cls_o = CLS_PUT_PART;
      OPC_GET:      cls_o = CLS_GET;
      default:      cls_o = CLS_BAD;
    endcase
  end
endmodule

// File: rtl/tlul_mask_check.sv
module tlul_mask_check
  import tlul_guard_pkg::*;
#(
  parameter int MASK_W = 4,
  parameter int SIZE_W = 2,
  parameter int CNT_W  = $clog2(MASK_W) + 1
) (
  input  req_cls_e          cls_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic              gap_o,
  output logic [CNT_W-1:0]  lanes_o,
  output guard_err_e        err_o
);
  localparam int MAX_SIZE = $clog2(MASK_W);

  // number of set bits in a lane vector
  function automatic logic [CNT_W-1:0] ones(input logic [MASK_W-1:0] v);
    logic [CNT_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < MASK_W; i++) acc = acc + {{(CNT_W-1){1'b0}}, v[i]};
    return acc;
  endfunction

  // byte count allowed by a size field
  function automatic logic [CNT_W-1:0] size_bytes(input logic [SIZE_W-1:0] s);
    return CNT_W'(1) << s;
  endfunction

  logic [MASK_W-1:0] run_start;
  logic [CNT_W-1:0]  lim;
  logic              size_big;
  logic              get_cnt_ok;

  // a lane begins a run when it is set and its lower neighbour is clear
  for (genvar i = 0; i < MASK_W; i++) begin : g_lane
    if (i == 0) begin : g_first
      assign run_start[i] = mask_i[i];
    end else begin : g_rest
      assign run_start[i] = mask_i[i] & ~mask_i[i-1];
    end
  end

  assign gap_o      = ones(run_start) > CNT_W'(1);
  assign lanes_o    = ones(mask_i);
  assign lim        = size_bytes(size_i);
  assign size_big   = size_i > SIZE_W'(MAX_SIZE);
  assign get_cnt_ok = (lanes_o <= lim) && ({lanes_o, 1'b0} > {1'b0, lim});

  always_comb begin
    err_o = ERR_NONE;
    if (cls_i == CLS_BAD) begin
      err_o = ERR_OPCODE;
    end else if (size_big) begin
      err_o = ERR_SIZE;
    end else begin
      unique case (cls_i)
        CLS_GET: begin
          if (gap_o)            err_o = ERR_GAP;
          else if (!get_cnt_ok) err_o = ERR_SIZE_MASK;
        end
        CLS_PUT_FULL: begin
          if (size_i != SIZE_W'(MAX_SIZE)) err_o = ERR_SIZE_MASK;
          else if (!(&mask_i))             err_o = ERR_PFD_LANES;
        end
        CLS_PUT_PART: begin
          if (lanes_o == '0 || lanes_o > lim) err_o = ERR_SIZE_MASK;
        end
        default: err_o = ERR_NONE;
      endcase
    end
  end
endmodule

// File: rtl/tlul_err_flop.sv
module tlul_err_flop
  import tlul_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       capture_i,
  input  guard_err_e err_i,
  output logic       viol_o,
  output logic [2:0] code_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_o <= 1'b0;
      code_o <= 3'd0;
    end else if (capture_i) begin
      viol_o <= (err_i != ERR_NONE);
      code_o <= err_i;
    end else begin
      viol_o <= 1'b0;
      code_o <= 3'd0;
    end
  end
endmodule

// File: rtl/tlul_req_guard.sv
module tlul_req_guard
  import tlul_guard_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SIZE_W = 2,
  parameter int MASK_W = DATA_W / 8,
  parameter int CNT_W  = $clog2(MASK_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_valid_i,
  input  logic [2:0]        a_opcode_i,
  input  logic [SIZE_W-1:0] a_size_i,
  input  logic [MASK_W-1:0] a_mask_i,
  output logic              a_ready_o,
  output logic              a_valid_o,
  output logic [2:0]        a_opcode_o,
  output logic [SIZE_W-1:0] a_size_o,
  output logic [MASK_W-1:0] a_mask_o,
  input  logic              a_ready_i,
  output logic              viol_o,
  output logic [2:0]        err_code_o
);
  // named internal events for the checker
  logic             acc_beat;
  logic             gap_seen;
  logic [CNT_W-1:0] lane_cnt;
  req_cls_e         cls;
  guard_err_e       beat_err;

  assign a_valid_o  = a_valid_i;
  assign a_opcode_o = a_opcode_i;
  assign a_size_o   = a_size_i;
  assign a_mask_o   = a_mask_i;
  assign a_ready_o  = a_ready_i;
  assign acc_beat   = a_valid_i & a_ready_i;

  tlul_opc_class u_cls (
    .opcode_i (a_opcode_i),
    .cls_o    (cls)
  );

  tlul_mask_check #(
    .MASK_W (MASK_W),
    .SIZE_W (SIZE_W),
    .CNT_W  (CNT_W)
  ) u_mask (
    .cls_i   (cls),
    .size_i  (a_size_i),
    .mask_i  (a_mask_i),
    .gap_o   (gap_seen),
    .lanes_o (lane_cnt),
    .err_o   (beat_err)
  );

  tlul_err_flop u_flop (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (acc_beat),
    .err_i     (beat_err),
    .viol_o    (viol_o),
    .code_o    (err_code_o)
  );
endmodule

// File: rtl/tlul_req_guard_chk.sv
module tlul_req_guard_chk #(
  parameter int SIZE_W = 2,
  parameter int MASK_W = 4,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_beat,
  input logic [2:0]        a_opcode_i,
  input logic [SIZE_W-1:0] a_size_i,
  input logic [MASK_W-1:0] a_mask_i,
  input logic              gap_seen,
  input logic [CNT_W-1:0]  lane_cnt,
  input logic              viol_o,
  input logic [2:0]        err_code_o
);
  localparam int MAX_SIZE = $clog2(MASK_W);

  logic op_legal;
  assign op_legal = (a_opcode_i == 3'd0) || (a_opcode_i == 3'd1) || (a_opcode_i == 3'd4);

  // R3
  flag_code_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o == (err_code_o != 3'd0));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_beat |=> (!viol_o && err_code_o == 3'd0));

  // R4
  bad_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_beat && !op_legal) |=> (err_code_o == 3'd1));

  // R5
  size_big_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_beat && op_legal && a_size_i > SIZE_W'(MAX_SIZE)) |=> (err_code_o == 3'd2));

  // R6
  get_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_beat && a_opcode_i == 3'd4 && a_size_i <= SIZE_W'(MAX_SIZE) && gap_seen)
    |=> (err_code_o == 3'd4));

  // R8
  full_write_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_beat && a_opcode_i == 3'd0 && a_size_i == SIZE_W'(MAX_SIZE) && (&a_mask_i))
    |=> !viol_o);

  // R9
  empty_partial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_beat && a_opcode_i == 3'd1 && a_size_i <= SIZE_W'(MAX_SIZE) && lane_cnt == '0)
    |=> (err_code_o == 3'd3));
endmodule

bind tlul_req_guard tlul_req_guard_chk #(
  .SIZE_W (SIZE_W),
  .MASK_W (MASK_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_beat   (acc_beat),
  .a_opcode_i (a_opcode_i),
  .a_size_i   (a_size_i),
  .a_mask_i   (a_mask_i),
  .gap_seen   (gap_seen),
  .lane_cnt   (lane_cnt),
  .viol_o     (viol_o),
  .err_code_o (err_code_o)
);

// File: tb/tb_tlul_req_guard.sv
`timescale 1ns/1ps
module tb_tlul_req_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       a_valid_i = 1'b0;
  logic [2:0] a_opcode_i = 3'd0;
  logic [1:0] a_size_i = 2'd0;
  logic [3:0] a_mask_i = 4'd0;
  logic       a_ready_i = 1'b0;
  logic       a_ready_o, a_valid_o, viol_o;
  logic [2:0] a_opcode_o, err_code_o;
  logic [1:0] a_size_o;
  logic [3:0] a_mask_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  tlul_req_guard dut (
    .clk(clk), .rst_n(rst_n),
    .a_valid_i(a_valid_i), .a_opcode_i(a_opcode_i), .a_size_i(a_size_i), .a_mask_i(a_mask_i),
    .a_ready_o(a_ready_o),
    .a_valid_o(a_valid_o), .a_opcode_o(a_opcode_o), .a_size_o(a_size_o), .a_mask_o(a_mask_o),
    .a_ready_i(a_ready_i),
    .viol_o(viol_o), .err_code_o(err_code_o)
  );

  // {opcode, size, mask, expected code}
  localparam int NV = 20;
  localparam logic [11:0] VEC [NV] = '{
    {3'd4, 2'd0, 4'b0001, 3'd0}, {3'd4, 2'd0, 4'b0011, 3'd3},
    {3'd4, 2'd1, 4'b0110, 3'd0}, {3'd4, 2'd1, 4'b1001, 3'd4},
    {3'd4, 2'd2, 4'b0111, 3'd0}, {3'd4, 2'd2, 4'b1111, 3'd0},
    {3'd4, 2'd2, 4'b0011, 3'd3}, {3'd4, 2'd2, 4'b1101, 3'd4},
    {3'd4, 2'd0, 4'b0000, 3'd3}, {3'd4, 2'd3, 4'b1111, 3'd2},
    {3'd0, 2'd2, 4'b1111, 3'd0}, {3'd0, 2'd1, 4'b1111, 3'd3},
    {3'd0, 2'd2, 4'b1110, 3'd5}, {3'd0, 2'd3, 4'b1111, 3'd2},
    {3'd1, 2'd0, 4'b1000, 3'd0}, {3'd1, 2'd1, 4'b1001, 3'd0},
    {3'd1, 2'd1, 4'b1011, 3'd3}, {3'd1, 2'd2, 4'b1101, 3'd0},
    {3'd2, 2'd0, 4'b0001, 3'd1}, {3'd7, 2'd3, 4'b0000, 3'd1}
  };

  // independent model: gap test via lowest-set-bit carry
  function automatic logic [2:0] model(input logic [2:0] op, input logic [1:0] sz, input logic [3:0] m);
    int cnt, lim;
    logic [3:0] low;
    cnt = 0;
    for (int i = 0; i < 4; i++) if (m[i]) cnt++;
    lim = 1 << sz;
    low = m & (~m + 4'd1);
    if (op != 3'd0 && op != 3'd1 && op != 3'd4) return 3'd1;
    if (sz > 2'd2) return 3'd2;
    if (op == 3'd4) begin
      if (((m + low) & m) != 4'd0) return 3'd4;
      if (!(cnt <= lim && cnt * 2 > lim)) return 3'd3;
      return 3'd0;
    end
    if (op == 3'd0) begin
      if (sz != 2'd2) return 3'd3;
      if (m != 4'b1111) return 3'd5;
      return 3'd0;
    end
    if (cnt == 0 || cnt > lim) return 3'd3;
    return 3'd0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one beat now, check pass-through, then result after the next edge
  task automatic beat(input logic v, input logic r, input logic [2:0] op, input logic [1:0] sz,
                      input logic [3:0] m, input logic [2:0] exp, input string req);
    a_valid_i = v; a_ready_i = r; a_opcode_i = op; a_size_i = sz; a_mask_i = m;
    #1;
    check(a_valid_o == v && a_ready_o == r && a_opcode_o == op && a_size_o == sz && a_mask_o == m,
          "R1", {a_valid_o, a_ready_o, a_opcode_o, a_size_o, a_mask_o}, {v, r, op, sz, m});
    @(posedge clk); #1;
    check(err_code_o == exp, req, err_code_o, exp);
    check(viol_o == (exp != 3'd0), "R3", viol_o, exp != 3'd0);
  endtask

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R10: illegal beat accepted while in reset
    a_valid_i = 1'b1; a_ready_i = 1'b1; a_opcode_i = 3'd7;
    repeat (3) @(posedge clk);
    #1;
    check(!viol_o && err_code_o == 3'd0, "R10", {viol_o, err_code_o}, 0);
    rst_n = 1'b1;
    a_valid_i = 1'b0;
    @(posedge clk); #1;

    for (int k = 0; k < NV; k++) begin
      beat(1'b1, 1'b1, VEC[k][11:9], VEC[k][8:7], VEC[k][6:3], VEC[k][2:0], "R4/R5/R6/R7/R8/R9 table");
    end

    // R2: bad beat not accepted (ready low, then valid low)
    beat(1'b1, 1'b0, 3'd7, 2'd3, 4'b1001, 3'd0, "R2 ready low");
    beat(1'b0, 1'b1, 3'd2, 2'd0, 4'b0000, 3'd0, "R2 valid low");
    // R2: result lasts one cycle only
    beat(1'b1, 1'b1, 3'd4, 2'd1, 4'b1001, 3'd4, "R6 gap");
    beat(1'b0, 1'b0, 3'd4, 2'd1, 4'b1001, 3'd0, "R2 one cycle");
    // back-to-back accepted beats
    beat(1'b1, 1'b1, 3'd0, 2'd2, 4'b0111, 3'd5, "R8 missing lane");
    beat(1'b1, 1'b1, 3'd1, 2'd0, 4'b0000, 3'd3, "R9 empty mask");
    beat(1'b1, 1'b1, 3'd5, 2'd2, 4'b1111, 3'd1, "R4 opcode 5");

    // full sweep over opcode, size and mask against the model
    for (int op = 0; op < 8; op++)
      for (int sz = 0; sz < 4; sz++)
        for (int m = 0; m < 16; m++)
          beat(1'b1, 1'b1, 3'(op), 2'(sz), 4'(m), model(3'(op), 2'(sz), 4'(m)), "R4-sweep R5 R6 R7 R8 R9");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule